// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block chooses the next control-memory address for a microprogrammed control unit. It holds a control address register that points into a control memory of 2^ADDR_W words (128 by default). It also holds a return-address register that remembers one level of subroutine call. Each clock cycle the fields of the current microinstruction select a branch type and a status condition, and supply a target address. Together these decide whether the address register steps forward, jumps to the target, calls a subroutine, returns from one, or jumps to the first word of the routine that belongs to the current machine opcode.

The status inputs come from the datapath: an indirect-addressing flag, the accumulator sign and an accumulator-is-zero flag. A fourth condition slot is tied high, so it gives unconditional branches. The control memory, the decoding of microoperations and the datapath sit outside this block. The address register output drives the control memory address, and the memory's word comes back as the field inputs.

Top module: `uprog_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both `car_q` and `sbr_q` become 0 at that edge.
- R2: `cond_sel` picks the branch condition: 00 = always true, 01 = `ind_bit`, 10 = `sign_bit`, 11 = `zero_bit`.
- R3: With `br_kind` = 00 (jump), a true selected condition loads `addr_field` into `car_q` and a false one loads `car_q + 1`.
- R4: With `br_kind` = 01 (call) and a true condition, `car_q` takes `addr_field` and `sbr_q` takes the old `car_q + 1` at the same edge.
- R5: With `br_kind` = 01 and a false condition, `car_q` takes `car_q + 1` and `sbr_q` keeps its value.
- R6: With `br_kind` = 10 (return), `car_q` takes `sbr_q`, whatever `cond_sel`, the status bits and `addr_field` hold.
- R7: With `br_kind` = 11 (map), `car_q` takes {0, `opcode`[3:0], 00}, whatever `cond_sel`, the status bits and `addr_field` hold.
- R8: The increment is 7 bits wide and wraps from 127 to 0.
- R9: `sbr_q` changes only on a call whose condition is true. Jumps, returns, maps and untaken calls leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_sel | input | 2 | Condition select field of the microinstruction |
| br_kind | input | 2 | Branch type field of the microinstruction |
| addr_field | input | 7 | Branch target field of the microinstruction |
| ind_bit | input | 1 | Indirect-mode status bit |
| sign_bit | input | 1 | Accumulator sign status bit |
| zero_bit | input | 1 | Accumulator-zero status bit |
| opcode | input | 4 | Opcode of the current machine instruction |
| car_q | output | 7 | Control address register |
| sbr_q | output | 7 | Subroutine return register |

## Verification
The hardest case to reach from the ports is a return that loads a return address which is itself the product of an earlier call. The stimulus must place a taken call first, then run some unrelated jumps, untaken calls and maps that must leave the return register alone, and only then issue the return. Directed sequences build this chain, including a call made from address 127, whose saved return address wraps to 0. Seeded random stimulus then interleaves all four branch types with random status bits, so that returns often pick up addresses saved many cycles earlier.

// File: rtl/useq_pkg.sv
// Shared encodings for the microprogram address sequencer.
// Assumes 2-bit branch-type and condition-select fields.
package useq_pkg;
    typedef enum logic [1:0] {
        BR_JMP  = 2'b00,
        BR_CALL = 2'b01,
        BR_RET  = 2'b10,
        BR_MAP  = 2'b11
    } br_kind_t;

    typedef enum logic [1:0] {
        CS_ALWAYS = 2'b00,
        CS_IND    = 2'b01,
        CS_SIGN   = 2'b10,
        CS_ZERO   = 2'b11
    } cond_sel_t;
endpackage

// File: rtl/useq_cond_mux.sv
// Condition multiplexer: returns the status bit chosen by the select field.
// Assumes the caller ties slot 0 high so that it gives unconditional branches.
module useq_cond_mux #(
    parameter int N_COND = 4,
    localparam int SEL_W = $clog2(N_COND)
) (
    input  logic [N_COND-1:0] cond_vec,
    input  logic [SEL_W-1:0]  sel,
    output logic              taken
);
    // Pick one condition from the vector.
    always_comb begin
        taken = 1'b0;
        for (int i = 0; i < N_COND; i++) begin
            if (sel == SEL_W'(i)) taken = cond_vec[i];
        end
    end
endmodule

// File: rtl/useq_next_addr.sv
// Next-address logic: chooses among increment, branch target, opcode map
// and saved return address, and decides whether the return register loads.
// Assumes ADDR_W >= OPC_W + SLOT_W + 1, with the map placed in the lower half.
module useq_next_addr
    import useq_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int OPC_W  = 4,
    parameter int SLOT_W = 2,
    localparam int PAD_W = ADDR_W - OPC_W - SLOT_W
) (
    input  logic [ADDR_W-1:0] car,
    input  logic [ADDR_W-1:0] sbr,
    input  br_kind_t          kind,
    input  logic              taken,
    input  logic [ADDR_W-1:0] target,
    input  logic [OPC_W-1:0]  opc,
    output logic [ADDR_W-1:0] car_nxt,
    output logic              sbr_load,
    output logic [ADDR_W-1:0] sbr_nxt
);
    logic [ADDR_W-1:0] car_inc;
    logic [ADDR_W-1:0] map_addr;

    // Wrapping increment and opcode-to-routine mapping.
    always_comb begin
        car_inc  = car + ADDR_W'(1);
        map_addr = {{PAD_W{1'b0}}, opc, {SLOT_W{1'b0}}};
    end

    // Select the next control address by branch type.
    always_comb begin
        sbr_load = 1'b0;
        sbr_nxt  = car_inc;
        unique case (kind)
            BR_JMP:  car_nxt = taken ? target : car_inc;
            BR_CALL: begin
                car_nxt  = taken ? target : car_inc;
                sbr_load = taken;
            end
            BR_RET:  car_nxt = sbr;
            BR_MAP:  car_nxt = map_addr;
            default: car_nxt = car_inc;
        endcase
    end
endmodule

// File: rtl/uprog_sequencer.sv
// Top of the microprogram address sequencer: holds the control address and
// return registers and updates them every rising edge.
// Assumes a synchronous active-low reset and one level of subroutine nesting.
module uprog_sequencer
    import useq_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int OPC_W  = 4,
    parameter int SLOT_W = 2,
    parameter int N_COND = 4,
    localparam int SEL_W = $clog2(N_COND)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  cond_sel,
    input  logic [1:0]        br_kind,
    input  logic [ADDR_W-1:0] addr_field,
    input  logic              ind_bit,
    input  logic              sign_bit,
    input  logic              zero_bit,
    input  logic [OPC_W-1:0]  opcode,
    output logic [ADDR_W-1:0] car_q,
    output logic [ADDR_W-1:0] sbr_q
);
    logic              taken;
    logic [ADDR_W-1:0] car_nxt;
    logic [ADDR_W-1:0] sbr_nxt;
    logic              sbr_load;
    logic [3:0]        cond_vec;

    // Gather the conditions; slot 0 is the constant-true input.
    always_comb cond_vec = {zero_bit, sign_bit, ind_bit, 1'b1};

    useq_cond_mux #(.N_COND(N_COND)) u_cmux (
        .cond_vec (cond_vec[N_COND-1:0]),
        .sel      (cond_sel),
        .taken    (taken)
    );

    useq_next_addr #(.ADDR_W(ADDR_W), .OPC_W(OPC_W), .SLOT_W(SLOT_W)) u_nxt (
        .car      (car_q),
        .sbr      (sbr_q),
        .kind     (br_kind_t'(br_kind)),
        .taken    (taken),
        .target   (addr_field),
        .opc      (opcode),
        .car_nxt  (car_nxt),
        .sbr_load (sbr_load),
        .sbr_nxt  (sbr_nxt)
    );

    // Control address register: reloads every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) car_q <= '0;
        else        car_q <= car_nxt;
    end

    // Return register: written only by a taken call.
    always_ff @(posedge clk) begin
        if (!rst_n)        sbr_q <= '0;
        else if (sbr_load) sbr_q <= sbr_nxt;
    end
endmodule

// File: rtl/uprog_sequencer_chk.sv
// Checker for the sequencer: relates the register outputs to the previous
// cycle's fields and status inputs. Assumes default widths (7/4/2).
module uprog_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cond_sel,
    input logic [1:0] br_kind,
    input logic [6:0] addr_field,
    input logic       ind_bit,
    input logic       sign_bit,
    input logic       zero_bit,
    input logic [3:0] opcode,
    input logic [6:0] car_q,
    input logic [6:0] sbr_q
);
    logic       cnd;
    logic [6:0] inc;

    // Expected condition value and increment, taken from the ports.
    always_comb begin
        case (cond_sel)
            2'b00:   cnd = 1'b1;
            2'b01:   cnd = ind_bit;
            2'b10:   cnd = sign_bit;
            default: cnd = zero_bit;
        endcase
        inc = car_q + 7'd1;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (car_q == 7'd0 && sbr_q == 7'd0));

    // R3
    jmp_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 2'b00 && cnd) |=> car_q == $past(addr_field));

    // R8
    jmp_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 2'b00 && !cnd) |=> car_q == $past(inc));

    // R4
    call_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 2'b01 && cnd) |=>
            (car_q == $past(addr_field) && sbr_q == $past(inc)));

    // R9
    sbr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(br_kind == 2'b01 && cnd) |=> $stable(sbr_q));

    // R6
    ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 2'b10) |=> car_q == $past(sbr_q));

    // R7
    map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 2'b11) |=> car_q == {1'b0, $past(opcode), 2'b00});
endmodule

bind uprog_sequencer uprog_sequencer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cond_sel   (cond_sel),
    .br_kind    (br_kind),
    .addr_field (addr_field),
    .ind_bit    (ind_bit),
    .sign_bit   (sign_bit),
    .zero_bit   (zero_bit),
    .opcode     (opcode),
    .car_q      (car_q),
    .sbr_q      (sbr_q)
);

// File: tb/uprog_sequencer_test.sv
module uprog_sequencer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cond_sel = 2'b00;
    logic [1:0] br_kind = 2'b00;
    logic [6:0] addr_field = 7'd0;
    logic       ind_bit = 1'b0;
    logic       sign_bit = 1'b0;
    logic       zero_bit = 1'b0;
    logic [3:0] opcode = 4'd0;
    logic [6:0] car_q;
    logic [6:0] sbr_q;

    int total = 0;
    int bad = 0;
    logic [6:0] m_car = 7'd0;
    logic [6:0] m_sbr = 7'd0;
    bit done = 1'b0;

    uprog_sequencer uut (
        .clk(clk), .rst_n(rst_n), .cond_sel(cond_sel), .br_kind(br_kind),
        .addr_field(addr_field), .ind_bit(ind_bit), .sign_bit(sign_bit),
        .zero_bit(zero_bit), .opcode(opcode), .car_q(car_q), .sbr_q(sbr_q)
    );

    always #10 clk = ~clk;   // 50 MHz

    function automatic logic cond_of(logic [1:0] cs, logic i, logic s, logic z);
        case (cs)
            2'b00:   return 1'b1;
            2'b01:   return i;
            2'b10:   return s;
            default: return z;
        endcase
    endfunction

    task automatic check(string tag, string what, logic [6:0] act, logic [6:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Drive one microinstruction, update the model, check after the edge.
    task automatic step(string tag, logic [1:0] cs, logic [1:0] bk, logic [6:0] ad,
                        logic i, logic s, logic z, logic [3:0] op);
        logic c;
        cond_sel = cs; br_kind = bk; addr_field = ad;
        ind_bit = i; sign_bit = s; zero_bit = z; opcode = op;
        c = cond_of(cs, i, s, z);
        case (bk)
            2'b00: m_car = c ? ad : m_car + 7'd1;
            2'b01: begin
                if (c) begin m_sbr = m_car + 7'd1; m_car = ad; end
                else m_car = m_car + 7'd1;
            end
            2'b10: m_car = m_sbr;
            default: m_car = {1'b0, op, 2'b00};
        endcase
        @(posedge clk);
        @(negedge clk);
        check(tag, "car", car_q, m_car);
        check(tag, "sbr", sbr_q, m_sbr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", "car", car_q, 7'd0);
        check("R1", "sbr", sbr_q, 7'd0);
        rst_n = 1'b1;

        // R3: jump, always true and false conditions
        step("R3", 2'b00, 2'b00, 7'd40, 0, 0, 0, 4'd0);
        step("R3", 2'b10, 2'b00, 7'd90, 0, 0, 0, 4'd0);
        // R2: each condition slot true then false
        step("R2", 2'b01, 2'b00, 7'd10, 1, 0, 0, 4'd0);
        step("R2", 2'b01, 2'b00, 7'd70, 0, 1, 1, 4'd0);
        step("R2", 2'b10, 2'b00, 7'd20, 0, 1, 0, 4'd0);
        step("R2", 2'b11, 2'b00, 7'd30, 1, 1, 0, 4'd0);
        step("R2", 2'b11, 2'b00, 7'd50, 0, 0, 1, 4'd0);
        // R4: taken call, then unrelated ops, then R6 return
        step("R4", 2'b10, 2'b01, 7'd100, 0, 1, 0, 4'd0);
        step("R5", 2'b11, 2'b01, 7'd5, 1, 1, 0, 4'd0);
        step("R9", 2'b00, 2'b00, 7'd60, 0, 0, 0, 4'd0);
        step("R7", 2'b00, 2'b11, 7'd99, 1, 1, 1, 4'd15);
        step("R7", 2'b01, 2'b11, 7'd33, 0, 0, 0, 4'd0);
        step("R6", 2'b01, 2'b10, 7'd77, 0, 0, 0, 4'd9);
        // R8: wrap from 127, also a call from 127
        step("R8", 2'b00, 2'b00, 7'd127, 0, 0, 0, 4'd0);
        step("R8", 2'b01, 2'b00, 7'd3, 0, 0, 0, 4'd0);
        step("R8", 2'b00, 2'b00, 7'd127, 0, 0, 0, 4'd0);
        step("R4", 2'b00, 2'b01, 7'd15, 0, 0, 0, 4'd0);
        step("R6", 2'b10, 2'b10, 7'd1, 1, 0, 1, 4'd0);

        // Seeded random mix of all branch types
        void'($urandom(32'd1234));
        for (int n = 0; n < 2000; n++) begin
            logic [1:0] bk;
            string tg;
            bk = 2'($urandom);
            case (bk)
                2'b00: tg = "R3";
                2'b01: tg = "R4";
                2'b10: tg = "R6";
                default: tg = "R7";
            endcase
            step(tg, 2'($urandom), bk, 7'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), 4'($urandom));
        end

        // R1: reset in mid-run
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", "car", car_q, 7'd0);
        check("R1", "sbr", sbr_q, 7'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule